// File: doc/BRIEF.md
# Serial Debug Transfer Command Engine

This block accepts serial debug frames one bit per accepted cycle and turns them into byte transfers on a simple memory port. One frame type stores a transfer setup (access kind, start address, length). Another frame returns the stored setup. A third frame runs the stored transfer. Every frame carries a CRC-32 check. Responses are shifted back on a serial output in the same cycle as the incoming bit. Each response ends with a 4-bit status field and an outbound CRC.

The alignment and size of a transfer are checked only when it is started. A failed check is reported through the status bits, and no memory access is made. The memory port handles one byte at a time with a request and acknowledge handshake. While a byte is being fetched or a buffered write burst runs, the serial input is held off through `bit_ready`. A write burst is held in a small buffer until its CRC has been verified, so a corrupted frame never reaches memory. The target module is chosen outside this block and is supplied as an enable.

Top module: `dbg_cmd_engine`

## Requirements
- R1: A frame starts with a one-cycle `frame_start` pulse. Bits are then accepted in cycles where `bit_valid` and `bit_ready` are both high. Bit 0 is a flag that must be 0, and bits 1 to 4 hold the opcode LSB first: 0 runs a transfer, 1 reads back the setup, 2 stores a setup. If `en` is low, the flag is 1 or the opcode is anything else, the rest of the frame is ignored: `bit_out` stays 0, the memory port stays idle and no state changes. After reset, `bit_ready` is 1 and `bit_out` and `mem_req` are 0.
- R2: Every CRC is CRC-32 with polynomial 0x04C11DB7. The register starts at all ones and takes bits in wire order: feedback is the register MSB XOR the bit, the register shifts left, and it is XORed with the polynomial when the feedback is 1. A CRC field goes on the wire LSB first.
- R3: The store-setup body is 4 access-type bits, then 32 address bits, then a 16-bit length (transfer size minus one), each LSB first, and then a CRC over the first 57 frame bits. On a match the three fields are stored and the setup becomes valid. On a mismatch the stored setup is left unchanged and the CRC-error status bit is set.
- R4: A readback frame is 5 header bits followed by a CRC over them. Output bits 0 to 36 are 0. Bits 37 to 88 are the stored access type, address and length field, LSB first. They are zero when no valid setup exists or the CRC check fails. The status and outbound CRC follow.
- R5: Each response for opcodes 0 to 2 ends with 4 status bits and a 32-bit CRC. Status bit 0 is CRC mismatch, bit 1 is bus error, and bits 2 and 3 are 0. The outbound CRC covers any returned setup or read data bits, then the status bits. A store-setup response is 89 zero bits before its status.
- R6: Access type bit 2 set means read, and bits 1:0 select the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Bit 3 must be 0 and a width code of 3 is invalid. A run frame with no valid setup, or with an invalid stored type, is ignored as in R1.
- R7: When a run frame with a correct CRC starts, the address and the size must both be multiples of the access width. If either is not, the bus-error bit is set, no memory access is made and the address is kept.
- R8: A read run frame is 5 header bits and a CRC over them. The response is 37 zero bits, then size bytes read from address upward, each byte LSB first, then status and CRC. `bit_ready` is low while a needed byte has not yet been returned.
- R9: A refused read (`mem_err`) sets the bus-error bit and ends the burst. The remaining data bits are 0 and are left out of the outbound CRC, and the address is kept.
- R10: A write run frame is 5 header bits, size data bytes each LSB first, then a CRC over the header and data. On a mismatch nothing is written and the CRC-error bit is set. Otherwise the bytes are written in order at address upward, before the status bits are shifted out.
- R11: A write run frame whose size exceeds BUF_BYTES sets the bus-error bit, and nothing is written.
- R12: After a burst that completes without error, in either direction, the stored address increases by the size. Within a write burst, consecutive requests use consecutive addresses.
- R13: `mem_req` stays high with a stable address, direction and write data until `mem_ack` or `mem_err` answers it.
- R14: A refused write ends the burst with the bus-error bit set. Bytes written before the refusal remain, and the address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | The memory target is the selected debug module |
| frame_start | input | 1 | Pulse that starts a new frame |
| bit_valid | input | 1 | Serial input bit present |
| bit_in | input | 1 | Serial input bit |
| bit_ready | output | 1 | Engine can take the bit this cycle |
| bit_out | output | 1 | Response bit paired with the accepted input bit |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access refused |

## Verification
A corrupt stored address or length first shows up at the ports as a wrong readback field. It also shows as wrong memory addresses on the very next run frame, which the final memory comparison and the readback after each burst both catch. A wrong phase count or CRC register moves or corrupts bits in the serial response, and that is caught at the first differing bit of the frame. A missed auto-increment or a mishandled refusal shows in the following readback frame. The random mix of setups, readbacks and bursts also exercises misaligned cases, CRC faults and address holes.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int          BUF_BYTES = 16,
  parameter logic [31:0] POLY      = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        frame_start,
  input  logic        bit_valid,
  input  logic        bit_in,
  output logic        bit_ready,
  output logic        bit_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err
);
  localparam int BW = $clog2(BUF_BYTES);
  localparam int CW = 20;

  typedef enum logic [3:0] {
    PH_IDLE, PH_HDR, PH_WC, PH_RCIN, PH_RCOUT, PH_RDATA,
    PH_WDATA, PH_WCRC, PH_WEXEC, PH_STAT, PH_CRCO
  } ph_t;

  ph_t         ph;
  logic [CW-1:0] cnt;
  logic [3:0]  hdr;
  logic [51:0] prm;
  logic [31:0] rx, crc_i, crc_o, addr_q;
  logic [3:0]  acc_q;
  logic [15:0] len_q;
  logic        setup_q, go_q, st_crc, st_bus, fetch_ok, have, pok;
  logic [7:0]  rbyte;
  logic [7:0]  wbuf [BUF_BYTES];

  function automatic logic [31:0] crc_nx(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? POLY : 32'h0);
  endfunction

  logic [16:0]   size;
  logic [CW-1:0] dlen;
  logic [1:0]    wmask;
  logic          mis, acc_ok, step, last, obit, ocount;
  logic [31:0]   rx_n;
  logic [4:0]    h;
  logic [16:0]   bidx;

  assign size   = {1'b0, len_q} + 17'd1;
  assign dlen   = {size, 3'b000};
  assign wmask  = (acc_q[1:0] == 2'd0) ? 2'b00 : (acc_q[1:0] == 2'd1) ? 2'b01 : 2'b11;
  assign mis    = (|(addr_q[1:0] & wmask)) | (|(size[1:0] & wmask));
  assign acc_ok = !acc_q[3] && (acc_q[1:0] != 2'b11);
  assign rx_n   = {bit_in, rx[31:1]};
  assign h      = {bit_in, hdr};
  assign bidx   = cnt[CW-1:3];

  assign bit_ready = (ph != PH_WEXEC) && !(ph == PH_RDATA && fetch_ok && !have);
  assign step      = bit_valid && bit_ready && !frame_start;
  assign mem_req   = (ph == PH_WEXEC) || (ph == PH_RDATA && fetch_ok && !have);
  assign mem_we    = (ph == PH_WEXEC);
  assign mem_addr  = addr_q + ((ph == PH_WEXEC) ? {12'b0, cnt} : {15'b0, bidx});
  assign mem_wdata = wbuf[cnt[BW-1:0]];
  assign bit_out   = obit;

  always_comb begin
    case (ph)
      PH_HDR:   last = (cnt == 20'd4);
      PH_WC:    last = (cnt == 20'd83);
      PH_RCIN:  last = (cnt == 20'd31);
      PH_RCOUT: last = (cnt == 20'd51);
      PH_RDATA: last = (cnt == dlen - 20'd1);
      PH_WDATA: last = (cnt == dlen - 20'd1);
      PH_WCRC:  last = (cnt == 20'd31);
      PH_STAT:  last = (cnt == 20'd3);
      PH_CRCO:  last = (cnt == 20'd31);
      default:  last = 1'b0;
    endcase
  end

  always_comb begin
    obit   = 1'b0;
    ocount = 1'b0;
    case (ph)
      PH_RCOUT: begin obit = prm[0]; ocount = pok; end
      PH_RDATA: begin obit = (fetch_ok && have) ? rbyte[cnt[2:0]] : 1'b0; ocount = fetch_ok && have; end
      PH_STAT:  begin
        obit   = (cnt[1:0] == 2'd0) ? st_crc : (cnt[1:0] == 2'd1) ? st_bus : 1'b0;
        ocount = 1'b1;
      end
      PH_CRCO:  obit = crc_o[0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk)
    if (step && ph == PH_WDATA && 32'(bidx) < BUF_BYTES)
      wbuf[bidx[BW-1:0]][cnt[2:0]] <= bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; hdr <= '0; prm <= '0; rx <= '0;
      crc_i <= '1; crc_o <= '1; addr_q <= '0; acc_q <= '0; len_q <= '0;
      setup_q <= 1'b0; go_q <= 1'b0; st_crc <= 1'b0; st_bus <= 1'b0;
      fetch_ok <= 1'b0; have <= 1'b0; pok <= 1'b0; rbyte <= '0;
    end else if (frame_start) begin
      ph <= PH_HDR; cnt <= '0; crc_i <= '1; crc_o <= '1;
      st_crc <= 1'b0; st_bus <= 1'b0; fetch_ok <= 1'b0; have <= 1'b0;
      pok <= 1'b0; go_q <= 1'b0;
    end else begin
      if (step) begin
        cnt <= last ? '0 : cnt + 20'd1;
        if (ph == PH_HDR || (ph == PH_WC && cnt < 20'd52) || ph == PH_WDATA)
          crc_i <= crc_nx(crc_i, bit_in);
        if (ocount) crc_o <= crc_nx(crc_o, obit);
        case (ph)
          PH_HDR: begin
            hdr <= h[4:1];
            if (last) begin
              if (!en || h[0]) ph <= PH_IDLE;
              else case (h[4:1])
                4'd2: ph <= PH_WC;
                4'd1: begin ph <= PH_RCIN; go_q <= 1'b0; end
                4'd0: if (setup_q && acc_ok) begin
                        if (acc_q[2]) begin ph <= PH_RCIN; go_q <= 1'b1; end
                        else ph <= PH_WDATA;
                      end else ph <= PH_IDLE;
                default: ph <= PH_IDLE;
              endcase
            end
          end
          PH_WC: begin
            if (cnt < 20'd52) prm <= {bit_in, prm[51:1]};
            else rx <= rx_n;
            if (last) begin
              if (rx_n == crc_i) begin
                acc_q <= prm[3:0]; addr_q <= prm[35:4]; len_q <= prm[51:36]; setup_q <= 1'b1;
              end else st_crc <= 1'b1;
              ph <= PH_STAT;
            end
          end
          PH_RCIN: begin
            rx <= rx_n;
            if (last) begin
              if (go_q) begin
                if (rx_n != crc_i) st_crc <= 1'b1;
                else if (mis) st_bus <= 1'b1;
                fetch_ok <= (rx_n == crc_i) && !mis;
                ph <= PH_RDATA;
              end else begin
                pok    <= (rx_n == crc_i) && setup_q;
                prm    <= ((rx_n == crc_i) && setup_q) ? {len_q, addr_q, acc_q} : '0;
                st_crc <= (rx_n != crc_i);
                ph     <= PH_RCOUT;
              end
            end
          end
          PH_RCOUT: begin
            prm <= prm >> 1;
            if (last) ph <= PH_STAT;
          end
          PH_RDATA: begin
            if (cnt[2:0] == 3'd7) have <= 1'b0;
            if (last) begin
              if (fetch_ok) addr_q <= addr_q + {15'b0, size};
              ph <= PH_STAT;
            end
          end
          PH_WDATA: if (last) ph <= PH_WCRC;
          PH_WCRC: begin
            rx <= rx_n;
            if (last) begin
              if (rx_n != crc_i) begin st_crc <= 1'b1; ph <= PH_STAT; end
              else if (mis || 32'(size) > BUF_BYTES) begin st_bus <= 1'b1; ph <= PH_STAT; end
              else ph <= PH_WEXEC;
            end
          end
          PH_STAT: if (last) ph <= PH_CRCO;
          PH_CRCO: begin
            crc_o <= crc_o >> 1;
            if (last) ph <= PH_IDLE;
          end
          default: ;
        endcase
      end
      if (ph == PH_RDATA && mem_req) begin
        if (mem_err) begin fetch_ok <= 1'b0; st_bus <= 1'b1; end
        else if (mem_ack) begin have <= 1'b1; rbyte <= mem_rdata; end
      end
      if (ph == PH_WEXEC) begin
        if (mem_err) begin st_bus <= 1'b1; ph <= PH_STAT; cnt <= '0; end
        else if (mem_ack) begin
          if (cnt == CW'(size - 17'd1)) begin
            addr_q <= addr_q + {15'b0, size};
            ph <= PH_STAT; cnt <= '0;
          end else cnt <= cnt + 20'd1;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err && !frame_start) |=> mem_req); // R13
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err && !frame_start) |=> ($stable(mem_addr) && $stable(mem_we))); // R13
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack && !mem_err && !frame_start) |=> $stable(mem_wdata)); // R13
  AST_WR_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !mem_err && !frame_start) |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd1)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> (!mem_req && !bit_out && bit_ready)); // R1
  AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STAT && cnt[1]) |-> !bit_out); // R5
endmodule

// File: tb/test_dbg_cmd_engine.sv
module test_dbg_cmd_engine;
  localparam int          BUF  = 16;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, frame_start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic bit_ready, bit_out, mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ack = 1'b0, mem_err = 1'b0;

  always #10 clk = ~clk;

  dbg_cmd_engine #(.BUF_BYTES(BUF), .POLY(POLY)) i_dbg_cmd_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
    .bit_valid(bit_valid), .bit_in(bit_in), .bit_ready(bit_ready), .bit_out(bit_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0]  mem [256];
  logic [7:0]  mm  [256];
  logic [7:0]  wd  [64];
  logic        m_valid = 1'b0;
  logic [3:0]  m_acc = '0;
  logic [31:0] m_addr = '0;
  logic [15:0] m_len = '0;
  logic [1023:0] tx, ex, rb;
  int nb;
  logic [31:0] ci, co;
  int wait_n = 0;

  function automatic logic [31:0] cnx(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? POLY : 32'h0);
  endfunction
  function automatic bit hole(input logic [31:0] a);
    return a[7:4] == 4'hE;
  endfunction
  function automatic bit acc_ok(input logic [3:0] a);
    return !a[3] && a[1:0] != 2'b11;
  endfunction
  function automatic bit misal(input logic [3:0] a, input logic [31:0] ad, input int sz);
    int w;
    w = (a[1:0] == 2'd0) ? 1 : (a[1:0] == 2'd1) ? 2 : 4;
    return (int'(ad % w) != 0) || (sz % w != 0);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack || mem_err) begin
        mem_ack = 1'b0; mem_err = 1'b0; wait_n = $urandom % 3;
      end else if (mem_req) begin
        if (wait_n > 0) wait_n--;
        else if (hole(mem_addr)) mem_err = 1'b1;
        else begin
          mem_ack = 1'b1;
          if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
          else mem_rdata = mem[mem_addr[7:0]];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic shift(input logic b, output logic o);
    @(negedge clk); bit_valid = 1'b1; bit_in = b; #1;
    while (!bit_ready) begin @(negedge clk); #1; end
    o = bit_out;
    @(posedge clk); #1; bit_valid = 1'b0;
  endtask

  task automatic begin_frame;
    nb = 0; ci = '1; co = '1;
  endtask
  task automatic put(input logic [31:0] v, input int n, input bit inc);
    for (int k = 0; k < n; k++) begin
      tx[nb] = v[k]; ex[nb] = 1'b0; if (inc) ci = cnx(ci, v[k]); nb++;
    end
  endtask
  task automatic expo(input logic [31:0] v, input int n, input bit inc);
    for (int k = 0; k < n; k++) begin
      tx[nb] = 1'b0; ex[nb] = v[k]; if (inc) co = cnx(co, v[k]); nb++;
    end
  endtask
  task automatic tail(input bit bus, input bit crcf);
    logic [31:0] s;
    expo({30'b0, bus, crcf}, 4, 1'b1);
    s = co;
    expo(s, 32, 1'b0);
  endtask

  task automatic run(input string tag);
    int bad;
    logic o;
    @(negedge clk); bit_valid = 1'b0; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < nb; i++) begin shift(tx[i], o); rb[i] = o; end
    bad = -1;
    for (int i = nb - 1; i >= 0; i--) if (rb[i] !== ex[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, "response", 0, 0);
    else chk(1'b0, tag, $sformatf("response bit %0d", bad), 64'(rb[bad]), 64'(ex[bad]));
  endtask

  task automatic wcmd(input logic [3:0] acc, input logic [31:0] ad, input logic [15:0] len, input bit bad, input string tag);
    logic [31:0] c;
    begin_frame;
    put(0, 1, 1'b1); put(2, 4, 1'b1); put(acc, 4, 1'b1); put(ad, 32, 1'b1); put(len, 16, 1'b1);
    c = ci ^ (bad ? 32'h8000_0000 : 32'h0);
    put(c, 32, 1'b0);
    tail(1'b0, bad);
    run(tag);
    if (!bad) begin m_valid = 1'b1; m_acc = acc; m_addr = ad; m_len = len; end
  endtask

  task automatic rcmd(input bit bad, input string tag);
    logic [31:0] c;
    begin_frame;
    put(0, 1, 1'b1); put(1, 4, 1'b1);
    c = ci ^ (bad ? 32'h1 : 32'h0);
    put(c, 32, 1'b0);
    if (m_valid && !bad) begin
      expo(m_acc, 4, 1'b1); expo(m_addr, 32, 1'b1); expo(m_len, 16, 1'b1);
    end else begin
      expo(0, 32, 1'b0); expo(0, 20, 1'b0);
    end
    tail(1'b0, bad);
    run(tag);
  endtask

  task automatic go_op(input bit bad, input string tag);
    int sz;
    bit mis, bus, live;
    logic [31:0] c, a;
    begin_frame;
    if (!m_valid || !acc_ok(m_acc)) begin
      put(0, 5, 1'b0); put(32'h5A5A_5A5A, 32, 1'b0);
      run(tag);
      return;
    end
    sz = int'(m_len) + 1;
    mis = misal(m_acc, m_addr, sz);
    put(0, 1, 1'b1); put(0, 4, 1'b1);
    if (m_acc[2]) begin
      c = ci ^ (bad ? 32'h100 : 32'h0);
      put(c, 32, 1'b0);
      bus = !bad && mis; live = !bad && !mis;
      for (int i = 0; i < sz; i++) begin
        a = m_addr + 32'(i);
        if (live && hole(a)) begin live = 1'b0; bus = 1'b1; end
        if (live) expo({24'b0, mm[a[7:0]]}, 8, 1'b1); else expo(0, 8, 1'b0);
      end
    end else begin
      for (int i = 0; i < sz; i++) put({24'b0, wd[i]}, 8, 1'b1);
      c = ci ^ (bad ? 32'h100 : 32'h0);
      put(c, 32, 1'b0);
      bus = !bad && (mis || sz > BUF);
      if (!bad && !bus)
        for (int i = 0; i < sz; i++) begin
          a = m_addr + 32'(i);
          if (hole(a)) begin bus = 1'b1; break; end
          mm[a[7:0]] = wd[i];
        end
    end
    tail(bus, bad);
    run(tag);
    if (!bad && !bus) m_addr = m_addr + 32'(sz);
  endtask

  task automatic fill_wd;
    for (int i = 0; i < 64; i++) wd[i] = 8'($urandom);
  endtask

  task automatic junk(input logic [4:0] hdr, input string tag);
    begin_frame;
    put({27'b0, hdr}, 5, 1'b0);
    put($urandom, 32, 1'b0); put($urandom, 32, 1'b0); put($urandom, 24, 1'b0);
    run(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r;
    logic [3:0] acc;
    logic [31:0] ad;
    int mism;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); mm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    #1;
    chk(bit_ready === 1'b1 && bit_out === 1'b0 && mem_req === 1'b0, "R1", "reset outputs",
        {61'b0, bit_ready, bit_out, mem_req}, 64'h4);
    rst_n = 1'b1;

    go_op(1'b0, "R6 go without setup");
    rcmd(1'b0, "R4 readback without setup");
    wcmd(4'd2, 32'h10, 16'd7, 1'b1, "R2/R3 bad setup crc");
    rcmd(1'b0, "R3 setup unchanged");
    wcmd(4'd2, 32'h10, 16'd7, 1'b0, "R3 setup store");
    rcmd(1'b0, "R4 readback");
    rcmd(1'b1, "R5 readback crc error");
    fill_wd; go_op(1'b0, "R10 write burst");
    rcmd(1'b0, "R12 address after write");
    wcmd(4'd6, 32'h10, 16'd7, 1'b0, "R3 read setup");
    go_op(1'b0, "R8 read burst");
    rcmd(1'b0, "R12 address after read");
    wcmd(4'd1, 32'h21, 16'd1, 1'b0, "R3");
    fill_wd; go_op(1'b0, "R7 misaligned write");
    rcmd(1'b0, "R7 address kept");
    wcmd(4'd6, 32'h20, 16'd5, 1'b0, "R3");
    go_op(1'b0, "R7 size not multiple");
    wcmd(4'd0, 32'h40, 16'd3, 1'b0, "R3");
    fill_wd; go_op(1'b1, "R10 write crc error");
    wcmd(4'd0, 32'h40, 16'd19, 1'b0, "R3");
    fill_wd; go_op(1'b0, "R11 write over buffer");
    wcmd(4'd4, 32'hDC, 16'd7, 1'b0, "R3");
    go_op(1'b0, "R9 read refused");
    rcmd(1'b0, "R9 address kept");
    wcmd(4'd0, 32'hDE, 16'd3, 1'b0, "R3");
    fill_wd; go_op(1'b0, "R14 write refused");
    rcmd(1'b0, "R14 address kept");
    wcmd(4'd3, 32'h00, 16'd0, 1'b0, "R3");
    go_op(1'b0, "R6 invalid type ignored");
    wcmd(4'd5, 32'h80, 16'd3, 1'b0, "R3");
    en = 1'b0; junk(5'b00100, "R1 disabled"); en = 1'b1;
    junk(5'b00001, "R1 flag set");
    junk(5'b00110, "R1 unknown opcode");
    junk(5'b01000, "R1 opcode 4");
    rcmd(1'b0, "R1 setup untouched");
    go_op(1'b0, "R8 read 16-bit");

    for (int it = 0; it < 60; it++) begin
      r = $urandom % 5;
      if (r == 0) begin
        case ($urandom % 8)
          0: acc = 4'd0; 1: acc = 4'd1; 2: acc = 4'd2; 3: acc = 4'd4;
          4: acc = 4'd5; 5: acc = 4'd6; 6: acc = 4'd7; default: acc = 4'd2;
        endcase
        ad = {24'b0, 8'($urandom)};
        if ($urandom % 3 != 0) ad[1:0] = 2'b00;
        wcmd(acc, ad, 16'($urandom % 16), ($urandom % 8) == 0, "R3 random setup");
      end else if (r == 1) rcmd(($urandom % 8) == 0, "R4 random readback");
      else begin
        fill_wd;
        go_op(($urandom % 8) == 0, "R8/R10 random burst");
      end
    end

    repeat (4) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) mism++;
    chk(mism == 0, "R10", "memory mismatches", 64'(mism), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule